// File: doc/BRIEF.md
# Control-Flow Sequencer with Engine Dispatch

This block walks a program held in an instruction memory and carries out its control flow. It loops on a loadable down-counter and branches on the outcome of a masked comparison against steering bytes that arrive from a serial link. It calls and returns from subroutines through a hardware stack that saves both the return address and the loop count. Output instructions are not executed here. They are pushed, in program order and ahead of time, into the instruction FIFOs of six output engines: engines 0 and 1 drive analog channels, and engines 2 to 5 drive markers. The output engines execute those instructions later at their own pace.

Two synchronization instructions coordinate the engines. The first places the same trigger-wait word into every engine FIFO in one cycle. The second holds the instruction stream until every engine FIFO has drained. The instruction memory has a one-cycle registered read. The sequencer can retire one instruction per cycle, and a taken jump costs no bubble.

Top module: `cfs_sequencer`

## Requirements
- R1: While `rst_ni` is low, the fetch address is 0, no engine write is issued, no steering byte is popped and `err_o` is 0.
- R2: Opcode 0 in bits [31:28] is an output instruction. Its whole 32-bit word is written to the engine FIFO selected by bits [27:24], in program order. A select value of 6 or higher causes no write and the program continues.
- R3: Opcode 3 loads bits [15:0] into the repeat counter. Opcode 4 continues with the next instruction when the counter is zero. Otherwise it decrements the counter and jumps to the target held in the low address bits of [15:0].
- R4: Opcode 5 pops one steering byte into the comparison register. While the steering input is empty it stalls and has no effect.
- R5: Opcode 6 stores a one-bit result. The result is (comparison register AND bits [15:8]) compared against bits [7:0], using the operator in bits [25:24]: 0 is equal, 1 is not equal, 2 is unsigned less-than, 3 is unsigned greater-than. The result is 0 after reset.
- R6: Opcode 7 jumps to its target when the condition in bits [25:24] holds. Condition 0 or 3 always holds, 1 holds when the stored result is 1, and 2 holds when it is 0.
- R7: Opcode 8 uses the same condition as R6. When the condition holds, it saves the next address and the repeat counter on the stack and jumps. Opcode 9 restores both saved values and resumes after the call.
- R8: An output instruction whose engine FIFO is full stalls the stream. A full FIFO is never written, and no later instruction overtakes the stalled one.
- R9: Opcode 2 lets no following instruction proceed until every engine FIFO reports empty.
- R10: Opcode 1 writes its word to all six engine FIFOs in the same cycle. It stalls while any of them is full.
- R11: A taken call when the stack is full, or a return when it is empty, sets `err_o`. The flag stays set until reset, and from then on no engine write and no steering pop occurs.
- R12: Opcodes 10 to 15 have no effect; the next instruction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | AW | Instruction memory read address |
| imem_data_i | input | 32 | Instruction word, one cycle after its address |
| steer_data_i | input | DW | Head byte of the steering input FIFO |
| steer_valid_i | input | 1 | Steering FIFO not empty |
| steer_rd_o | output | 1 | Pop the steering head byte |
| eng_wr_o | output | NA+NM | Per-engine FIFO write strobe |
| eng_data_o | output | 32 | Instruction word written to the engine FIFOs |
| eng_full_i | input | NA+NM | Per-engine FIFO full |
| eng_empty_i | input | NA+NM | Per-engine FIFO empty |
| err_o | output | 1 | Sticky stack-fault flag; the sequencer is halted |

## Verification
The bench builds the block with a 64-word program space (AW=6) and a four-entry stack (SD=4). With the four-entry stack, a self-recursive subroutine overflows on its fifth call, so R11 is reached within a few dozen cycles. The bench models the engine FIFOs with a depth of four, so one held-off engine fills after four writes. This exposes the full stall, head-of-line blocking, the drain barrier and the delayed broadcast. The comparison cases include a byte with its top bit set, which makes a signed greater-than give the wrong answer.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [3:0] {
    OP_OUT    = 4'd0,
    OP_WAIT   = 4'd1,
    OP_SYNC   = 4'd2,
    OP_LDREP  = 4'd3,
    OP_REPEAT = 4'd4,
    OP_LDCMP  = 4'd5,
    OP_CMP    = 4'd6,
    OP_GOTO   = 4'd7,
    OP_CALL   = 4'd8,
    OP_RET    = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GT = 2'd3
  } cmp_e;

  typedef enum logic [1:0] {
    CND_ALL = 2'd0,
    CND_SET = 2'd1,
    CND_CLR = 2'd2,
    CND_ANY = 2'd3
  } cnd_e;
endpackage

// File: rtl/cfs_fetch.sv
module cfs_fetch #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          jump_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic [AW-1:0] cur_o
);
  logic [AW-1:0] pc_q, cur_q;
  logic          vld_q;

  // memory read is registered: the address chosen now is the word decoded next cycle
  always_comb begin
    if (!vld_q)      addr_o = pc_q;
    else if (hold_i) addr_o = cur_q;
    else if (jump_i) addr_o = target_i;
    else             addr_o = pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      cur_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      cur_q <= addr_o;
      pc_q  <= addr_o + 1'b1;
    end
  end

  assign valid_o = vld_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/cfs_stack.sv
module cfs_stack #(
  parameter int AW = 10,
  parameter int RW = 16,
  parameter int SD = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [RW-1:0] push_rep_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] top_addr_o,
  output logic [RW-1:0] top_rep_o
);
  localparam int PW = $clog2(SD + 1);
  localparam int XW = (SD > 1) ? $clog2(SD) : 1;

  logic [PW-1:0] sp_q;
  logic [AW-1:0] addr_q [SD];
  logic [RW-1:0] rep_q  [SD];
  logic [XW-1:0] top_ix;

  assign full_o  = (sp_q == PW'(SD));
  assign empty_o = (sp_q == '0);
  assign top_ix  = empty_o ? '0 : XW'(sp_q - 1'b1);
  assign top_addr_o = addr_q[top_ix];
  assign top_rep_o  = rep_q[top_ix];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= '0;
    else if (push_i && !full_o) sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < SD; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        rep_q[g]  <= '0;
      end else if (push_i && sp_q == PW'(g)) begin
        addr_q[g] <= push_addr_i;
        rep_q[g]  <= push_rep_i;
      end
    end
  end
endmodule

// File: rtl/cfs_branch.sv
module cfs_branch
  import cfs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          cmp_i,
  input  cmp_e          op_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] oper_i,
  input  cnd_e          cnd_i,
  output logic          taken_o
);
  logic [DW-1:0] cmp_q, lhs;
  logic          flag_q, res;

  assign lhs = cmp_q & mask_i;

  always_comb begin
    case (op_i)
      CMP_EQ: res = (lhs == oper_i);
      CMP_NE: res = (lhs != oper_i);
      CMP_LT: res = (lhs <  oper_i);
      CMP_GT: res = (lhs >  oper_i);
    endcase
  end

  always_comb begin
    case (cnd_i)
      CND_SET: taken_o = flag_q;
      CND_CLR: taken_o = !flag_q;
      default: taken_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load_i) cmp_q  <= load_data_i;
      if (cmp_i)  flag_q <= res;
    end
  end
endmodule

// File: rtl/cfs_dispatch.sv
module cfs_dispatch #(
  parameter int NE   = 6,
  parameter int SELW = 4,
  parameter int IW   = 32
) (
  input  logic            out_i,
  input  logic            bcast_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [IW-1:0]   word_i,
  input  logic [NE-1:0]   full_i,
  output logic [NE-1:0]   wr_o,
  output logic [IW-1:0]   data_o,
  output logic            block_o
);
  logic [NE-1:0] hit;

  for (genvar g = 0; g < NE; g++) begin : g_eng
    assign hit[g] = bcast_i || (out_i && sel_i == SELW'(g));
  end

  // any addressed engine full holds the whole word back
  assign block_o = |(hit & full_i);
  assign wr_o    = block_o ? '0 : hit;
  assign data_o  = word_i;
endmodule

// File: rtl/cfs_sequencer.sv
module cfs_sequencer
  import cfs_pkg::*;
#(
  parameter int AW = 10,
  parameter int NA = 2,
  parameter int NM = 4,
  parameter int SD = 8,
  parameter int RW = 16,
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [AW-1:0]      imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic [DW-1:0]      steer_data_i,
  input  logic               steer_valid_i,
  output logic               steer_rd_o,
  output logic [NA+NM-1:0]   eng_wr_o,
  output logic [INSTR_W-1:0] eng_data_o,
  input  logic [NA+NM-1:0]   eng_full_i,
  input  logic [NA+NM-1:0]   eng_empty_i,
  output logic               err_o
);
  localparam int NE   = NA + NM;
  localparam int SELW = 4;

  logic          vld, act, err_q;
  logic [AW-1:0] cur;
  op_e           op;
  logic is_out, is_wait, is_sync, is_ldrep, is_rep, is_ldcmp, is_cmp, is_goto, is_call, is_ret;
  logic          disp_blk, stall, taken;
  logic          stk_full, stk_empty, push, ovf, unf, ret_ok, rep_jmp, jump, hold;
  logic [AW-1:0] top_addr, target;
  logic [RW-1:0] rep_q, top_rep;

  assign act = vld && !err_q;
  assign op  = op_e'(imem_data_i[31:28]);

  always_comb begin
    {is_out, is_wait, is_sync, is_ldrep, is_rep, is_ldcmp, is_cmp, is_goto, is_call, is_ret} = '0;
    if (act) begin
      case (op)
        OP_OUT:    is_out   = 1'b1;
        OP_WAIT:   is_wait  = 1'b1;
        OP_SYNC:   is_sync  = 1'b1;
        OP_LDREP:  is_ldrep = 1'b1;
        OP_REPEAT: is_rep   = 1'b1;
        OP_LDCMP:  is_ldcmp = 1'b1;
        OP_CMP:    is_cmp   = 1'b1;
        OP_GOTO:   is_goto  = 1'b1;
        OP_CALL:   is_call  = 1'b1;
        OP_RET:    is_ret   = 1'b1;
        default: ;
      endcase
    end
  end

  cfs_dispatch #(.NE(NE), .SELW(SELW), .IW(INSTR_W)) u_disp (
    .out_i   (is_out),
    .bcast_i (is_wait),
    .sel_i   (imem_data_i[27:24]),
    .word_i  (imem_data_i),
    .full_i  (eng_full_i),
    .wr_o    (eng_wr_o),
    .data_o  (eng_data_o),
    .block_o (disp_blk)
  );

  assign steer_rd_o = is_ldcmp && steer_valid_i;

  cfs_branch #(.DW(DW)) u_br (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (steer_rd_o),
    .load_data_i (steer_data_i),
    .cmp_i       (is_cmp),
    .op_i        (cmp_e'(imem_data_i[25:24])),
    .mask_i      (imem_data_i[8 +: DW]),
    .oper_i      (imem_data_i[0 +: DW]),
    .cnd_i       (cnd_e'(imem_data_i[25:24])),
    .taken_o     (taken)
  );

  assign push    = is_call && taken && !stk_full;
  assign ovf     = is_call && taken && stk_full;
  assign ret_ok  = is_ret && !stk_empty;
  assign unf     = is_ret && stk_empty;
  assign rep_jmp = is_rep && (rep_q != '0);

  cfs_stack #(.AW(AW), .RW(RW), .SD(SD)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (ret_ok),
    .push_addr_i (cur + 1'b1),
    .push_rep_i  (rep_q),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .top_addr_o  (top_addr),
    .top_rep_o   (top_rep)
  );

  assign stall  = disp_blk || (is_sync && !(&eng_empty_i)) || (is_ldcmp && !steer_valid_i);
  assign jump   = rep_jmp || (is_goto && taken) || push || ret_ok;
  assign target = ret_ok ? top_addr : imem_data_i[AW-1:0];
  assign hold   = stall || err_q || ovf || unf;

  cfs_fetch #(.AW(AW)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .jump_i   (jump),
    .target_i (target),
    .addr_o   (imem_addr_o),
    .valid_o  (vld),
    .cur_o    (cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ovf || unf)   err_q <= 1'b1;
      if (is_ldrep)     rep_q <= imem_data_i[RW-1:0];
      else if (rep_jmp) rep_q <= rep_q - 1'b1;
      else if (ret_ok)  rep_q <= top_rep;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/cfs_sequencer_chk.sv
module cfs_sequencer_chk #(
  parameter int NE = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NE-1:0] eng_wr_o,
  input logic [NE-1:0] eng_full_i,
  input logic [31:0]   eng_data_o,
  input logic          steer_rd_o,
  input logic          steer_valid_i,
  input logic          err_o
);
  assert_no_write_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_wr_o & eng_full_i) == '0);

  assert_one_or_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_wr_o) || (&eng_wr_o));

  assert_bcast_is_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&eng_wr_o) |-> (eng_data_o[31:28] == 4'd1));

  assert_pop_has_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_rd_o |-> steer_valid_i);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_halt_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (eng_wr_o == '0 && !steer_rd_o));
endmodule

bind cfs_sequencer cfs_sequencer_chk #(.NE(NE)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .eng_wr_o      (eng_wr_o),
  .eng_full_i    (eng_full_i),
  .eng_data_o    (eng_data_o),
  .steer_rd_o    (steer_rd_o),
  .steer_valid_i (steer_valid_i),
  .err_o         (err_o)
);

// File: tb/cfs_sequencer_tb_top.sv
`timescale 1ns/1ps
module cfs_sequencer_tb_top;
  localparam int AW = 6, NE = 6, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_q, e_data;
  logic [7:0]    s_data;
  logic          s_valid, s_rd, err;
  logic [NE-1:0] e_wr, e_full, e_empty, drain;

  cfs_sequencer #(.AW(AW), .SD(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_q),
    .steer_data_i(s_data), .steer_valid_i(s_valid), .steer_rd_o(s_rd),
    .eng_wr_o(e_wr), .eng_data_o(e_data), .eng_full_i(e_full), .eng_empty_i(e_empty),
    .err_o(err)
  );

  logic [31:0] prog [64];
  always @(posedge clk) imem_q <= prog[imem_addr];

  logic [2:0] occ [NE];
  always @(posedge clk)
    for (int e = 0; e < NE; e++)
      if (!rst_n) occ[e] <= '0;
      else occ[e] <= occ[e] + 3'(e_wr[e]) - 3'(drain[e] && occ[e] != 3'd0);
  always_comb
    for (int e = 0; e < NE; e++) begin
      e_full[e]  = (occ[e] >= 3'(DEPTH));
      e_empty[e] = (occ[e] == 3'd0);
    end

  logic [7:0] sbuf [16];
  logic [4:0] shead, stail;
  always @(posedge clk)
    if (!rst_n) shead <= '0;
    else if (s_rd) shead <= shead + 1'b1;
  assign s_valid = shead < stail;
  assign s_data  = sbuf[shead[3:0]];

  logic [31:0] expq [NE][$];
  int wr_cnt [NE];
  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [31:0] exp_w;

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (|e_wr && e_data[31:28] == 4'd1) begin
      checks++;
      if (e_wr != '1) begin
        errors++;
        $display("FAIL R10 broadcast strobes got %b exp %b", e_wr, {NE{1'b1}});
      end
    end
    for (int e = 0; e < NE; e++) if (e_wr[e]) begin
      wr_cnt[e]++;
      checks++;
      if (expq[e].size() == 0) begin
        errors++;
        $display("FAIL %s engine %0d got %h exp none", cur_req, e, e_data);
      end else begin
        exp_w = expq[e].pop_front();
        if (exp_w !== e_data) begin
          errors++;
          $display("FAIL %s engine %0d got %h exp %h", cur_req, e, e_data, exp_w);
        end
      end
    end
  end

  function automatic logic [31:0] w_out(int e, int p);    return {4'd0, 4'(e), 24'(p)}; endfunction
  function automatic logic [31:0] w_wait(int p);          return {4'd1, 28'(p)}; endfunction
  function automatic logic [31:0] w_sync();               return {4'd2, 28'd0}; endfunction
  function automatic logic [31:0] w_ldrep(int n);         return {4'd3, 12'd0, 16'(n)}; endfunction
  function automatic logic [31:0] w_rep(int t);           return {4'd4, 12'd0, 16'(t)}; endfunction
  function automatic logic [31:0] w_ldcmp();              return {4'd5, 28'd0}; endfunction
  function automatic logic [31:0] w_cmp(int op, int m, int v);
    return {4'd6, 2'd0, 2'(op), 8'd0, 8'(m), 8'(v)};
  endfunction
  function automatic logic [31:0] w_goto(int c, int t);   return {4'd7, 2'd0, 2'(c), 8'd0, 16'(t)}; endfunction
  function automatic logic [31:0] w_call(int c, int t);   return {4'd8, 2'd0, 2'(c), 8'd0, 16'(t)}; endfunction
  function automatic logic [31:0] w_ret();                return {4'd9, 28'd0}; endfunction

  function automatic bit ref_cmp(int op, logic [7:0] c, logic [7:0] m, logic [7:0] v);
    logic [7:0] a;
    a = c & m;
    case (op)
      0: return a == v;
      1: return a != v;
      2: return a < v;
      default: return a > v;
    endcase
  endfunction

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", r, got, exp);
    end
  endtask

  task automatic ex(int e, logic [31:0] w); expq[e].push_back(w); endtask

  task automatic begin_prog(string r);
    @(negedge clk);
    rst_n = 1'b0;
    cur_req = r;
    for (int i = 0; i < 64; i++) prog[i] = w_goto(0, i);
    for (int e = 0; e < NE; e++) begin
      expq[e].delete();
      wr_cnt[e] = 0;
    end
    drain = '1;
    stail = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic go(int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic chk_drained(string r);
    for (int e = 0; e < NE; e++) chk(r, 32'(expq[e].size()), 32'd0);
  endtask

  task automatic add_case(int i, int base, int op, int m, int v, int cnd, logic [7:0] b);
    bit r, tk;
    r  = ref_cmp(op, b, 8'(m), 8'(v));
    tk = (cnd == 1) ? r : (cnd == 2) ? !r : 1'b1;
    prog[base]   = w_ldcmp();
    prog[base+1] = w_cmp(op, m, v);
    prog[base+2] = w_goto(cnd, base + 5);
    prog[base+3] = w_out(0, 'h400 + 2 * i);
    prog[base+4] = w_goto(0, base + 6);
    prog[base+5] = w_out(0, 'h401 + 2 * i);
    ex(0, w_out(0, 'h400 + 2 * i + int'(tk)));
  endtask

  initial begin
    drain = '1;
    stail = '0;
    for (int i = 0; i < 64; i++) prog[i] = w_goto(0, i);

    // R1 reset state
    begin_prog("R1");
    chk("R1 fetch addr", 32'(imem_addr), 32'd0);
    chk("R1 writes", 32'(e_wr), 32'd0);
    chk("R1 steer pop", 32'(s_rd), 32'd0);
    chk("R1 err", 32'(err), 32'd0);

    // R2 dispatch to every engine, out-of-range select, R12 unused opcode
    begin_prog("R2");
    for (int e = 0; e < NE; e++) begin
      prog[e] = w_out(e, 'h101 + e);
      ex(e, w_out(e, 'h101 + e));
    end
    prog[6] = w_out(7, 'h1FF);
    prog[7] = {4'd12, 28'h0000_0AB};
    prog[8] = w_out(3, 'h1AA);
    ex(3, w_out(3, 'h1AA));
    prog[9] = w_goto(0, 9);
    go(30);
    chk_drained("R2");
    chk("R12 no halt", 32'(err), 32'd0);

    // R3 repeat loops
    begin_prog("R3");
    prog[0] = w_ldrep(2);
    prog[1] = w_out(1, 'h200);
    prog[2] = w_rep(1);
    prog[3] = w_ldrep(0);
    prog[4] = w_out(2, 'h300);
    prog[5] = w_rep(4);
    prog[6] = w_out(0, 'h3FF);
    prog[7] = w_goto(0, 7);
    repeat (3) ex(1, w_out(1, 'h200));
    ex(2, w_out(2, 'h300));
    ex(0, w_out(0, 'h3FF));
    go(30);
    chk_drained("R3");

    // R4 R5 R6 compare and conditional jump, unsigned compare, empty stall
    begin_prog("R5");
    add_case(0, 0,  0, 'h0F, 'h05, 1, 8'hA5);
    add_case(1, 6,  1, 'hFF, 'h3C, 1, 8'h3C);
    add_case(2, 12, 2, 'hFF, 'h81, 2, 8'h80);
    add_case(3, 18, 3, 'hF0, 'h20, 2, 8'h10);
    add_case(4, 24, 3, 'hFF, 'h7F, 1, 8'hC3);
    prog[30] = w_goto(0, 30);
    sbuf[0] = 8'hA5; sbuf[1] = 8'h3C; sbuf[2] = 8'h80; sbuf[3] = 8'h10; sbuf[4] = 8'hC3;
    stail = 5'd4;
    go(80);
    chk("R4 stall on empty", 32'(wr_cnt[0]), 32'd4);
    chk("R4 no pop when empty", 32'(shead), 32'd4);
    stail = 5'd5;
    repeat (20) @(negedge clk);
    chk_drained("R6");

    // R7 call/return with saved repeat count, conditional call not taken
    begin_prog("R7");
    prog[0] = w_call(1, 6);
    prog[1] = w_ldrep(1);
    prog[2] = w_call(0, 6);
    prog[3] = w_rep(2);
    prog[4] = w_out(3, 'h5EE);
    prog[5] = w_goto(0, 5);
    prog[6] = w_out(2, 'h511);
    prog[7] = w_ldrep(7);
    prog[8] = w_ret();
    repeat (2) ex(2, w_out(2, 'h511));
    ex(3, w_out(3, 'h5EE));
    go(40);
    chk_drained("R7");
    chk("R7 no fault", 32'(err), 32'd0);

    // R8 full engine stalls the stream in order
    begin_prog("R8");
    for (int i = 0; i < 6; i++) begin
      prog[i] = w_out(0, 'h600 + i);
      ex(0, w_out(0, 'h600 + i));
    end
    prog[6] = w_out(1, 'h6F0);
    ex(1, w_out(1, 'h6F0));
    prog[7] = w_goto(0, 7);
    drain[0] = 1'b0;
    go(30);
    chk("R8 writes to full engine", 32'(wr_cnt[0]), 32'(DEPTH));
    chk("R8 no overtake", 32'(wr_cnt[1]), 32'd0);
    drain[0] = 1'b1;
    repeat (30) @(negedge clk);
    chk_drained("R8");

    // R9 drain barrier
    begin_prog("R9");
    prog[0] = w_out(4, 'h700);
    prog[1] = w_sync();
    prog[2] = w_out(5, 'h701);
    prog[3] = w_goto(0, 3);
    ex(4, w_out(4, 'h700));
    ex(5, w_out(5, 'h701));
    drain[4] = 1'b0;
    go(30);
    chk("R9 held behind barrier", 32'(wr_cnt[5]), 32'd0);
    drain[4] = 1'b1;
    repeat (20) @(negedge clk);
    chk_drained("R9");

    // R10 broadcast wait, held while one engine is full
    begin_prog("R10");
    for (int i = 0; i < 4; i++) begin
      prog[i] = w_out(2, 'h800 + i);
      ex(2, w_out(2, 'h800 + i));
    end
    prog[4] = w_wait('h8AA);
    for (int e = 0; e < NE; e++) ex(e, w_wait('h8AA));
    prog[5] = w_out(0, 'h8BB);
    ex(0, w_out(0, 'h8BB));
    prog[6] = w_goto(0, 6);
    drain[2] = 1'b0;
    go(30);
    chk("R10 broadcast held", 32'(wr_cnt[0]), 32'd0);
    chk("R10 filled engine", 32'(wr_cnt[2]), 32'd4);
    drain[2] = 1'b1;
    repeat (30) @(negedge clk);
    chk_drained("R10");

    // R11 stack overflow
    begin_prog("R11");
    prog[0] = w_out(0, 'h900);
    prog[1] = w_call(0, 0);
    repeat (5) ex(0, w_out(0, 'h900));
    go(40);
    chk_drained("R11 overflow");
    chk("R11 overflow flag", 32'(err), 32'd1);
    repeat (10) @(negedge clk);
    chk("R11 flag sticky", 32'(err), 32'd1);
    chk("R11 halted", 32'(wr_cnt[0]), 32'd5);

    // R11 stack underflow
    begin_prog("R11");
    prog[0] = w_ret();
    prog[1] = w_out(0, 'h9AA);
    prog[2] = w_ldcmp();
    sbuf[0] = 8'h11;
    stail = 5'd1;
    go(20);
    chk("R11 underflow flag", 32'(err), 32'd1);
    chk("R11 no write", 32'(wr_cnt[0]), 32'd0);
    chk("R11 no pop", 32'(shead), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog got 1 exp 0", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule